// File: doc/BRIEF.md
# ADC Offset and Gain Calibration Sequencer

This block sits after the decimation filter of a sigma-delta converter. The filter delivers one signed word with a one-clock strobe every 64 clocks. In normal operation, each word has a stored offset subtracted from it. The difference is then scaled by a stored gain factor, and the result is presented with a valid flag.

On a calibration request, the block waits for the conversion in flight to finish. It then drives a two-bit analog input-select output through a fixed set of reference conditions. For each condition it lets the filter settle for a fixed interval and then averages eight filter words. From these averages it computes a new offset and a new gain factor. The gain factor comes from a multicycle restoring divider.

The sequence depends on the input mode, which is captured when the request is accepted. The unipolar sequence takes two measurements. The bipolar sequence takes three. A rising edge on the sync input, or a synchronous reset, abandons a calibration part way through.

Top module: `adc_cal_seq`

## Requirements
- R1: Reset clears the offset to 0 and sets the gain to unity (16384 in unsigned Q2.14). After reset, in_sel is 00, out_valid is 0, rdy_n is 0 and cal_done is 0, so a filter word x is reproduced as x.
- R2: Outside calibration, each filt_stb loads out_data with sat16(((x - offset) * gain) >>> 14), computed with floor shift, one clock after the strobe. out_valid is then 1.
- R3: cal_req is sampled on a rising edge only while the block is idle. Calibration begins on the edge of the next filt_stb, at most 64 clocks later, and the word of that strobe is discarded. From that edge rdy_n is 1 and out_valid is 0.
- R4: For each condition the block waits 8192 clocks. It then averages the next eight strobed words as their 19-bit sum arithmetically shifted right by 3 (floor). in_sel moves on one clock after the eighth word.
- R5: Unipolar sequence: in_sel is 01 (shorted) and then 10 (plus full scale). The offset becomes the shorted average. The gain becomes floor(32767 * 2^14 / (plus average - shorted average)).
- R6: Bipolar sequence: in_sel is 01, then 10, then 11 (minus reference). The offset becomes the shorted average. The gain becomes floor(65535 * 2^14 / (plus average - minus average)). The mode is latched at the request, and later changes of bipolar have no effect on the running sequence.
- R7: A gain quotient above 65535 is clamped to 65535. A measured span of zero or less leaves the gain unchanged while the offset is still loaded.
- R8: When the results are loaded, cal_done pulses for exactly one clock and in_sel is 00. rdy_n stays 1 and out_valid stays 0 for a further 8192 clocks. out_valid rises on the first strobe after that interval.
- R9: A rising edge on sync_in during calibration returns the block to idle on that edge: rdy_n 0, in_sel 00, no cal_done and the stored offset and gain unchanged. Asserting rst during calibration also abandons it and restores the R1 state.
- R10: The corrected output saturates to 32767 and -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_req | input | 1 | Calibration request, sampled high on a rising edge |
| bipolar | input | 1 | Input mode: 1 bipolar, 0 unipolar |
| sync_in | input | 1 | Synchronisation input; a rising edge aborts calibration |
| filt_stb | input | 1 | One-clock strobe marking a new filter word |
| filt_data | input | 16 | Signed filter output word |
| in_sel | output | 2 | Input select: 00 pins, 01 shorted, 10 plus reference, 11 minus reference |
| out_data | output | 16 | Signed corrected output word |
| out_valid | output | 1 | Corrected output holds valid data |
| rdy_n | output | 1 | High while calibration holds the output invalid |
| cal_done | output | 1 | One-clock pulse when a calibration completes |

## Verification
The hardest cases to reach from the ports are those that depend on the analog readings each reference condition would produce: a zero measured span, a gain big enough to clamp, and an average that must round toward minus infinity. The bench answers in_sel with its own filter model. That model returns a chosen level per condition plus a period-eight jitter whose sum over any eight words is -3, so every window's average is one below the level whichever strobes it covers. Setting the plus level equal to the shorted level gives the zero span, and a small span gives the clamp. The corrected outputs that follow then show which offset and gain were stored.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int GAIN_W    = 16;
    localparam int GAIN_FRAC = 14;
    localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'(1 << GAIN_FRAC);

    typedef enum logic [1:0] {
        SEL_PINS  = 2'b00,
        SEL_SHORT = 2'b01,
        SEL_PLUS  = 2'b10,
        SEL_MINUS = 2'b11
    } sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SETTLE,
        ST_MEAS,
        ST_DIV_START,
        ST_DIVIDE,
        ST_POST
    } cal_state_e;

    function automatic sel_e phase_sel(input logic [1:0] ph);
        case (ph)
            2'd0:    return SEL_SHORT;
            2'd1:    return SEL_PLUS;
            default: return SEL_MINUS;
        endcase
    endfunction

endpackage

// File: rtl/cal_averager.sv
module cal_averager #(
    parameter int DW    = 16,
    parameter int LOG2N = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 stb,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] avg,
    output logic                 avg_vld
);
    localparam int AW = DW + LOG2N;

    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] sum;
    logic [LOG2N-1:0]     cnt;

    assign sum = acc + {{LOG2N{din[DW-1]}}, din};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc     <= '0;
            cnt     <= '0;
            avg_vld <= 1'b0;
        end else begin
            avg_vld <= 1'b0;
            if (stb) begin
                if (cnt == '1) begin
                    acc     <= '0;
                    cnt     <= '0;
                    avg_vld <= 1'b1;
                end else begin
                    acc <= sum;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            avg <= '0;
        end else if (stb && !clear && cnt == '1) begin
            avg <= sum[AW-1:LOG2N];
        end
    end

    AST_AVG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        avg_vld |=> !avg_vld);                                   // R4
    AST_AVG_FROM_STB: assert property (@(posedge clk) disable iff (rst)
        avg_vld |-> $past(stb));                                 // R4

endmodule

// File: rtl/cal_divider.sv
module cal_divider #(
    parameter int NUM_W = 30,
    parameter int DEN_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic             done
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem;
    logic [DEN_W-1:0] den_q;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic [CNT_W-1:0] cnt;
    logic             busy;

    assign trial = {rem, quo[NUM_W-1]};
    assign diff  = trial - {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem   <= '0;
            den_q <= '0;
            quo   <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem   <= '0;
                den_q <= den;
                quo   <= num;
                cnt   <= CNT_W'(NUM_W);
                busy  <= 1'b1;
            end else if (busy) begin
                if (trial >= {1'b0, den_q}) begin
                    rem <= diff[DEN_W-1:0];
                    quo <= {quo[NUM_W-2:0], 1'b1};
                end else begin
                    rem <= trial[DEN_W-1:0];
                    quo <= {quo[NUM_W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                         // R7

endmodule

// File: rtl/cal_corrector.sv
module cal_corrector
    import cal_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pass,
    input  logic                  stb,
    input  logic signed [DW-1:0]  din,
    input  logic signed [DW-1:0]  offset,
    input  logic [GAIN_W-1:0]     gain,
    output logic signed [DW-1:0]  dout,
    output logic                  valid
);
    localparam int PW = DW + GAIN_W + 2;
    localparam logic signed [PW-1:0] MAXV = PW'((2 ** (DW - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

    logic signed [DW:0]   diff;
    logic signed [PW-1:0] diff_x;
    logic signed [PW-1:0] gain_x;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;
    logic signed [DW-1:0] sat;

    always_comb begin
        diff   = {din[DW-1], din} - {offset[DW-1], offset};
        diff_x = PW'(diff);
        gain_x = $signed({{(PW - GAIN_W){1'b0}}, gain});
        prod   = diff_x * gain_x;
        scaled = prod >>> GAIN_FRAC;
        if (scaled > MAXV)      sat = MAXV[DW-1:0];
        else if (scaled < MINV) sat = MINV[DW-1:0];
        else                    sat = scaled[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= '0;
            valid <= 1'b0;
        end else if (!pass) begin
            valid <= 1'b0;
        end else if (stb) begin
            dout  <= sat;
            valid <= 1'b1;
        end
    end

    AST_VALID_AFTER_STB: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(stb));                            // R2

endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
    import cal_pkg::*;
#(
    parameter int DW          = 16,
    parameter int SETTLE_CLKS = 8192,
    parameter int AVG_LOG2    = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cal_req,
    input  logic                 bipolar,
    input  logic                 sync_in,
    input  logic                 filt_stb,
    input  logic signed [DW-1:0] filt_data,
    output logic [1:0]           in_sel,
    output logic signed [DW-1:0] out_data,
    output logic                 out_valid,
    output logic                 rdy_n,
    output logic                 cal_done
);
    localparam int SW    = DW + 1;
    localparam int NUM_W = DW + GAIN_FRAC;
    localparam int CW    = $clog2(SETTLE_CLKS + 1);
    localparam int UNI_SPAN = (2 ** (DW - 1)) - 1;
    localparam int BI_SPAN  = (2 ** DW) - 1;
    localparam logic [NUM_W-1:0] NUM_UNI = NUM_W'(UNI_SPAN) << GAIN_FRAC;
    localparam logic [NUM_W-1:0] NUM_BI  = NUM_W'(BI_SPAN) << GAIN_FRAC;

    cal_state_e           st;
    logic [1:0]           ph;
    logic                 mode_bi;
    logic [CW-1:0]        cnt;
    logic                 sync_q;
    logic                 sync_rise;
    logic                 last_ph;
    logic                 cnt_end;

    logic signed [DW-1:0] offset_q;
    logic [GAIN_W-1:0]    gain_q;
    logic signed [DW-1:0] zero_avg;
    logic signed [DW-1:0] plus_avg;
    logic signed [DW-1:0] minus_avg;
    logic signed [DW-1:0] lower_avg;
    logic signed [SW-1:0] span;

    logic signed [DW-1:0] avg;
    logic                 avg_vld;
    logic                 div_start;
    logic [NUM_W-1:0]     div_num;
    logic [NUM_W-1:0]     div_quo;
    logic                 div_done;
    logic [GAIN_W-1:0]    gain_next;
    logic                 pass;

    assign sync_rise = sync_in & ~sync_q;
    assign last_ph   = mode_bi ? (ph == 2'd2) : (ph == 2'd1);
    assign cnt_end   = (cnt == CW'(SETTLE_CLKS - 1));
    assign lower_avg = mode_bi ? minus_avg : zero_avg;
    assign span      = $signed({plus_avg[DW-1], plus_avg}) - $signed({lower_avg[DW-1], lower_avg});
    assign div_start = (st == ST_DIV_START) && (span > 0);
    assign div_num   = mode_bi ? NUM_BI : NUM_UNI;
    assign gain_next = (|div_quo[NUM_W-1:GAIN_W]) ? '1 : div_quo[GAIN_W-1:0];
    assign rdy_n     = !((st == ST_IDLE) || (st == ST_WAIT));
    assign pass      = (st == ST_IDLE) || ((st == ST_WAIT) && !filt_stb);
    assign in_sel    = ((st == ST_SETTLE) || (st == ST_MEAS)) ? phase_sel(ph) : SEL_PINS;

    cal_averager #(.DW(DW), .LOG2N(AVG_LOG2)) u_avg (
        .clk     (clk),
        .rst     (rst),
        .clear   (st != ST_MEAS),
        .stb     (filt_stb && (st == ST_MEAS)),
        .din     (filt_data),
        .avg     (avg),
        .avg_vld (avg_vld)
    );

    cal_divider #(.NUM_W(NUM_W), .DEN_W(SW)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (div_num),
        .den   (span[SW-1:0]),
        .quo   (div_quo),
        .done  (div_done)
    );

    cal_corrector #(.DW(DW)) u_corr (
        .clk    (clk),
        .rst    (rst),
        .pass   (pass),
        .stb    (filt_stb),
        .din    (filt_data),
        .offset (offset_q),
        .gain   (gain_q),
        .dout   (out_data),
        .valid  (out_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ph        <= '0;
            mode_bi   <= 1'b0;
            cnt       <= '0;
            sync_q    <= 1'b0;
            offset_q  <= '0;
            gain_q    <= GAIN_UNITY;
            zero_avg  <= '0;
            plus_avg  <= '0;
            minus_avg <= '0;
            cal_done  <= 1'b0;
        end else begin
            sync_q   <= sync_in;
            cal_done <= 1'b0;
            if (sync_rise && st != ST_IDLE) begin
                st  <= ST_IDLE;
                ph  <= '0;
                cnt <= '0;
            end else begin
                case (st)
                    ST_IDLE: begin
                        if (cal_req) begin
                            st      <= ST_WAIT;
                            mode_bi <= bipolar;
                        end
                    end
                    ST_WAIT: begin
                        if (filt_stb) begin
                            st  <= ST_SETTLE;
                            ph  <= '0;
                            cnt <= '0;
                        end
                    end
                    ST_SETTLE: begin
                        if (cnt_end) begin
                            st  <= ST_MEAS;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_MEAS: begin
                        if (avg_vld) begin
                            case (ph)
                                2'd0:    zero_avg  <= avg;
                                2'd1:    plus_avg  <= avg;
                                default: minus_avg <= avg;
                            endcase
                            if (last_ph) begin
                                st <= ST_DIV_START;
                            end else begin
                                ph  <= ph + 1'b1;
                                st  <= ST_SETTLE;
                                cnt <= '0;
                            end
                        end
                    end
                    ST_DIV_START: begin
                        if (span > 0) begin
                            st <= ST_DIVIDE;
                        end else begin
                            offset_q <= zero_avg;
                            cal_done <= 1'b1;
                            st       <= ST_POST;
                            cnt      <= '0;
                        end
                    end
                    ST_DIVIDE: begin
                        if (div_done) begin
                            gain_q   <= gain_next;
                            offset_q <= zero_avg;
                            cal_done <= 1'b1;
                            st       <= ST_POST;
                            cnt      <= '0;
                        end
                    end
                    ST_POST: begin
                        if (cnt_end) begin
                            st  <= ST_IDLE;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    AST_NO_VALID_IN_CAL: assert property (@(posedge clk) disable iff (rst)
        rdy_n |-> !out_valid);                                   // R3
    AST_PINS_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        !rdy_n |-> (in_sel == SEL_PINS));                        // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> !cal_done);                                 // R8
    AST_SYNC_ABORT: assert property (@(posedge clk) disable iff (rst)
        (sync_in && !sync_q && rdy_n) |=> !rdy_n);               // R9
    AST_GAIN_HELD: assert property (@(posedge clk) disable iff (rst)
        (st != ST_DIVIDE) |=> $stable(gain_q));                  // R7

endmodule

// File: tb/adc_cal_seq_tb.sv
module adc_cal_seq_tb;

    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst;
    logic               cal_req;
    logic               bipolar;
    logic               sync_in;
    logic               filt_stb;
    logic signed [15:0] filt_data;
    logic [1:0]         in_sel;
    logic signed [15:0] out_data;
    logic               out_valid;
    logic               rdy_n;
    logic               cal_done;

    int     errors = 0;
    int     checks = 0;
    int     lvl_short = 0, lvl_plus = 0, lvl_minus = 0, pin_val = 0;
    longint cur_off = 0, cur_gain = 16384;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_cal_seq u_dut (
        .clk       (clk),
        .rst       (rst),
        .cal_req   (cal_req),
        .bipolar   (bipolar),
        .sync_in   (sync_in),
        .filt_stb  (filt_stb),
        .filt_data (filt_data),
        .in_sel    (in_sel),
        .out_data  (out_data),
        .out_valid (out_valid),
        .rdy_n     (rdy_n),
        .cal_done  (cal_done)
    );

    function automatic int jit(int k);
        case (k % 8)
            0: return 3;  1: return -1; 2: return 2;  3: return -4;
            4: return 0;  5: return 1;  6: return -2; default: return -2;
        endcase
    endfunction

    function automatic longint exp_corr(longint x, longint off, longint g);
        longint s;
        s = ((x - off) * g) >>> 14;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    function automatic longint exp_gain(longint ideal, longint span, longint old);
        longint q;
        if (span <= 0) return old;
        q = (ideal * 16384) / span;
        if (q > 65535) q = 65535;
        return q;
    endfunction

    // filter model: answers the input select with a level per condition
    initial begin
        int k;
        int v;
        k = 0;
        filt_stb = 1'b0;
        filt_data = '0;
        forever begin
            repeat (63) @(negedge clk);
            case (in_sel)
                2'b01:   v = lvl_short + jit(k);
                2'b10:   v = lvl_plus + jit(k);
                2'b11:   v = lvl_minus + jit(k);
                default: v = pin_val;
            endcase
            filt_data = 16'(v);
            filt_stb  = 1'b1;
            @(negedge clk);
            filt_stb = 1'b0;
            k++;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input longint act, input longint lo, input longint hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wait_stb();
        do @(posedge clk); while (filt_stb !== 1'b1);
    endtask

    task automatic word_check(input string req, input int x);
        pin_val = x;
        wait_stb();
        wait_stb();
        @(negedge clk);
        chk(req, out_data, exp_corr(x, cur_off, cur_gain));
        chk(req, out_valid, 1);
    endtask

    task automatic start_cal(input bit bi);
        int n;
        @(negedge clk);
        bipolar = bi;
        cal_req = 1'b1;
        @(negedge clk);
        cal_req = 1'b0;
        n = 1;
        while (!rdy_n && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk_range("R3 start latency", n, 1, 66);
        chk("R3 valid low in cal", out_valid, 0);
        chk("R5 first select shorted", in_sel, 1);
    endtask

    task automatic wait_done(input string req, output int n);
        n = 0;
        while (!cal_done && n < 30000) begin
            @(negedge clk);
            n++;
        end
        chk(req, cal_done, 1);
        chk("R8 select back to pins", in_sel, 0);
        @(negedge clk);
        chk("R8 done one clock", cal_done, 0);
    endtask

    task automatic wait_post_settle();
        int n;
        repeat (8000) @(negedge clk);
        chk("R8 valid low in settle", out_valid, 0);
        chk("R8 rdy_n high in settle", rdy_n, 1);
        n = 8001;
        while (!out_valid && n < 9000) begin
            @(negedge clk);
            n++;
        end
        chk_range("R8 valid after settle", n, 8193, 8192 + 66);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", out_valid, 0);
        chk("R1 rdy_n after reset", rdy_n, 0);
        chk("R1 select after reset", in_sel, 0);
        chk("R1 done after reset", cal_done, 0);
        cur_off = 0;
        cur_gain = 16384;
        word_check("R1 unity positive", 12345);
        word_check("R2 unity negative", -7);
    endtask

    task automatic test_unipolar();
        int n;
        bit saw_minus;
        lvl_short = -200;
        lvl_plus = 30000;
        start_cal(1'b0);
        bipolar = 1'b1;                       // R6: must not change the sequence
        n = 0;
        while (in_sel == 2'b01 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk_range("R4 settle plus window", n, 8192 + 448, 8192 + 528);
        chk("R5 second select plus", in_sel, 2);
        saw_minus = 1'b0;
        n = 0;
        while (!cal_done && n < 20000) begin
            @(negedge clk);
            n++;
            if (in_sel == 2'b11) saw_minus = 1'b1;
        end
        chk("R6 mode latched no minus", saw_minus, 0);
        chk("R8 unipolar done", cal_done, 1);
        chk("R8 select back to pins", in_sel, 0);
        @(negedge clk);
        chk("R8 done one clock", cal_done, 0);
        bipolar = 1'b0;
        wait_post_settle();
        cur_off = lvl_short - 1;
        cur_gain = exp_gain(32767, (lvl_plus - 1) - (lvl_short - 1), cur_gain);
        word_check("R5 unipolar correction", 1000);
        word_check("R4 floor average offset", -3000);
    endtask

    task automatic test_sync_abort();
        int n;
        bit saw_done;
        lvl_short = 5000;
        lvl_plus = 5100;
        start_cal(1'b0);
        repeat (1000) @(negedge clk);
        sync_in = 1'b1;
        @(negedge clk);
        chk("R9 sync abort rdy_n", rdy_n, 0);
        chk("R9 sync abort select", in_sel, 0);
        sync_in = 1'b0;
        saw_done = 1'b0;
        for (n = 0; n < 300; n++) begin
            @(negedge clk);
            if (cal_done) saw_done = 1'b1;
        end
        chk("R9 no done after abort", saw_done, 0);
        word_check("R9 registers kept", 2500);
    endtask

    task automatic test_bipolar();
        int n;
        lvl_short = 50;
        lvl_plus = 31000;
        lvl_minus = -30000;
        start_cal(1'b1);
        bipolar = 1'b0;
        n = 0;
        while (in_sel == 2'b01 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk("R6 bipolar second plus", in_sel, 2);
        n = 0;
        while (in_sel == 2'b10 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk("R6 bipolar third minus", in_sel, 3);
        chk_range("R4 bipolar plus window", n, 8192 + 448, 8192 + 528);
        wait_done("R6 bipolar done", n);
        chk_range("R6 minus phase length", n, 8192 + 448, 8192 + 600);
        wait_post_settle();
        cur_off = lvl_short - 1;
        cur_gain = exp_gain(65535, (lvl_plus - 1) - (lvl_minus - 1), cur_gain);
        word_check("R6 bipolar correction pos", 25000);
        word_check("R6 bipolar correction neg", -20000);
    endtask

    task automatic test_zero_span();
        int n;
        lvl_short = 300;
        lvl_plus = 300;
        start_cal(1'b0);
        wait_done("R7 zero span done", n);
        wait_post_settle();
        cur_off = lvl_short - 1;
        word_check("R7 zero span gain kept", 4000);
    endtask

    task automatic test_clamp_sat();
        int n;
        lvl_short = 0;
        lvl_plus = 100;
        start_cal(1'b0);
        wait_done("R7 clamp done", n);
        wait_post_settle();
        cur_off = -1;
        cur_gain = exp_gain(32767, 100, cur_gain);
        chk("R7 bench gain clamps", cur_gain, 65535);
        word_check("R7 clamped gain", 100);
        word_check("R10 saturate high", 20000);
        word_check("R10 saturate low", -20000);
    endtask

    task automatic test_rst_abort();
        lvl_short = 700;
        lvl_plus = 9000;
        start_cal(1'b1);
        repeat (500) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset abort rdy_n", rdy_n, 0);
        chk("R9 reset abort select", in_sel, 0);
        cur_off = 0;
        cur_gain = 16384;
        word_check("R9 reset restores unity", 5000);
    endtask

    initial begin
        #(CLK_PERIOD * 195000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cal_req = 1'b0;
        bipolar = 1'b0;
        sync_in = 1'b0;
        test_reset();
        test_unipolar();
        test_sync_abort();
        test_bipolar();
        test_zero_span();
        test_clamp_sat();
        test_rst_abort();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule